// File: doc/BRIEF.md
# General-call address-read bus master

This block is a two-wire serial bus master that runs one fixed transaction. The transaction reads back the bus address bits of a converter device. It opens with a START and writes the general-call address 00h. It then writes the command byte 0Ch. After a repeated START it writes a read header of the form 1100 followed by a three-bit device select and a 1. Finally it reads one byte from the target, acknowledges that byte itself and closes with a STOP. The two bus lines are open drain. The block drives an output-enable for each line, where 1 means pull the line low, and it takes the resolved SDA level back as an input.

Alongside the bus the block drives a sideband latch strobe, which idles high. The strobe has to fall inside the SCL low time that follows clock 8 of the second byte, and it must stay low until SCL rises for clock 9 of the third byte. Both edges are generated from the same registered phase decode as SCL, so they line up with SCL exactly. When the target leaves any of the first three bytes unacknowledged, the master sends a STOP at once, returns the strobe high and reports an error.

The bus rate comes from a divider of the system clock, sampled when the transaction starts. Each SCL period is split into four equal phases. The divider must be set so that SCL stays at or below 400 kHz.

Top module: `gc_addr_reader`

## Requirements
- R1: After reset, sclOe=0, sdaOe=0, strobeOut=1, done=0 and error=0.
- R2: Each bus phase lasts divider+1 clocks, using the divider value sampled with start. A data or acknowledge clock keeps SCL low for two phases and then high for two phases, so the bit period is 4*(divider+1) clocks. The first phase appears on the outputs two clock edges after the edge that samples start.
- R3: START (SDA falls while SCL is high) is followed by 00h, then 0Ch, then a repeated START, then {1100, devSel[2:0], 1}, each byte MSB first. Outside START, repeated START and STOP, sdaOe changes only while SCL is low.
- R4: During each target acknowledge clock the master releases SDA (sdaOe=0). It samples SDA at the end of the first SCL-high phase, and a low level means acknowledged.
- R5: strobeOut falls in the second phase (SCL low) of the acknowledge clock of byte 2. It stays low through the repeated START and byte 3, and rises together with SCL in the third phase of the acknowledge clock of byte 3.
- R6: During the 8 read clocks the master releases SDA and shifts the sampled bits in MSB first. It then pulls SDA low for its own acknowledge clock and sends STOP (SCL released in phase 1, SDA released in phase 2). As STOP ends, done pulses for one clock, error=0 and rdData holds the byte.
- R7: If the target does not acknowledge byte 1, 2 or 3, a STOP slot follows that acknowledge clock directly, with strobeOut high from its first phase. done then pulses with error=1, and rdData keeps its earlier value.
- R8: start is ignored while a transaction is running. A pulse with a different divider or devSel leaves the waveform and its length unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (taken only when idle) |
| divider | input | DIV_W | Phase length minus one, in clocks |
| devSel | input | 3 | Device select bits placed into the read header |
| sdaIn | input | 1 | Resolved SDA line level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| strobeOut | output | 1 | Sideband latch strobe, idles high |
| rdData | output | 8 | Byte read in the last data phase |
| done | output | 1 | One-clock pulse when STOP completes |
| error | output | 1 | Set with done when a target acknowledge was missing |

## Verification
The hardest situation to reach is an abort that happens while the strobe is already low. This is a missing acknowledge on byte 2, where the strobe fell one phase earlier in the same clock and must be raised in the first phase of the abort STOP. The bench reaches it with a behavioural target that acknowledges selectively: per run it withholds the pull on exactly one acknowledge clock and leaves the others intact. Aborts on bytes 1 and 3 are run the same way. A start pulse in the middle of a transaction carries a different divider and device select, and the bench compares the whole phase-by-phase waveform against the undisturbed expectation.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

  localparam logic [7:0] GC_ADDR_WR  = 8'h00;
  localparam logic [7:0] CMD_RD_ADDR = 8'h0C;
  localparam logic [3:0] RD_PREFIX   = 4'b1100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_WBIT,
    ST_WACK,
    ST_RESTART,
    ST_RBIT,
    ST_MACK,
    ST_STOP
  } gcrState_t;

  typedef struct packed {
    logic       clrTick;
    logic       run;
    logic       loadTx;
    logic [7:0] txByte;
    logic       sample;
    logic       shift;
    logic       capture;
  } dpCtl_t;

endpackage

// File: rtl/gcr_datapath.sv
module gcr_datapath
  import gcr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [DIV_W-1:0] divider,
  input  logic             sdaIn,
  output logic             tick,
  output logic             txBit,
  output logic             sampledBit,
  output logic [7:0]       rdData
);

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] tickCnt;
  logic [7:0]       shiftReg;

  assign tick  = ctl.run && (tickCnt == divReg);
  assign txBit = shiftReg[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg     <= '0;
      tickCnt    <= '0;
      shiftReg   <= '0;
      sampledBit <= 1'b1;
      rdData     <= '0;
    end else begin
      if (ctl.clrTick) begin
        divReg  <= divider;
        tickCnt <= '0;
      end else if (!ctl.run || tick) begin
        tickCnt <= '0;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
      if (ctl.sample)       sampledBit <= sdaIn;
      if (ctl.loadTx)       shiftReg   <= ctl.txByte;
      else if (ctl.shift)   shiftReg   <= {shiftReg[6:0], sampledBit};
      if (ctl.capture)      rdData     <= shiftReg;
    end
  end

  a_r2_phase_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= divReg);

  a_r2_divider_held_while_running: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run && $past(ctl.run) |-> $stable(divReg));

endmodule

// File: rtl/gcr_control.sv
module gcr_control
  import gcr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] devSel,
  input  logic       tick,
  input  logic       txBit,
  input  logic       sampledBit,
  output dpCtl_t     ctl,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       strobeOut,
  output logic       done,
  output logic       error
);

  gcrState_t  state;
  logic [1:0] q;
  logic [2:0] bitCnt;
  logic [1:0] byteCnt;
  logic [2:0] devReg;
  logic       strobeLow;
  logic       abortFlag;
  logic       busCondOut;
  logic       idle;
  logic       slotEnd;
  logic       sclLowNext;
  logic       sdaLowNext;
  logic       busCondNext;

  assign idle    = (state == ST_IDLE);
  assign slotEnd = tick && (q == 2'd3);

  always_comb begin
    ctl         = '0;
    ctl.clrTick = idle && start;
    ctl.run     = !idle;
    ctl.sample  = tick && (q == 2'd2);
    ctl.shift   = slotEnd && (state == ST_WBIT || state == ST_RBIT);
    ctl.capture = slotEnd && (state == ST_STOP) && !abortFlag;
    if (slotEnd) begin
      if (state == ST_START) begin
        ctl.loadTx = 1'b1;
        ctl.txByte = GC_ADDR_WR;
      end else if (state == ST_WACK && byteCnt == 2'd0 && !sampledBit) begin
        ctl.loadTx = 1'b1;
        ctl.txByte = CMD_RD_ADDR;
      end else if (state == ST_RESTART) begin
        ctl.loadTx = 1'b1;
        ctl.txByte = {RD_PREFIX, devReg, 1'b1};
      end
    end
  end

  always_comb begin
    sclLowNext  = 1'b0;
    sdaLowNext  = 1'b0;
    busCondNext = 1'b0;
    unique case (state)
      ST_IDLE:    ;
      ST_START: begin
        sdaLowNext  = q[1];
        busCondNext = 1'b1;
      end
      ST_WBIT: begin
        sclLowNext = !q[1];
        sdaLowNext = !txBit;
      end
      ST_WACK, ST_RBIT: sclLowNext = !q[1];
      ST_MACK: begin
        sclLowNext = !q[1];
        sdaLowNext = 1'b1;
      end
      ST_RESTART: begin
        sclLowNext  = (q == 2'd0);
        sdaLowNext  = q[1];
        busCondNext = 1'b1;
      end
      ST_STOP: begin
        sclLowNext  = (q == 2'd0);
        sdaLowNext  = !q[1];
        busCondNext = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      q          <= '0;
      bitCnt     <= '0;
      byteCnt    <= '0;
      devReg     <= '0;
      strobeLow  <= 1'b0;
      abortFlag  <= 1'b0;
      done       <= 1'b0;
      error      <= 1'b0;
      sclOe      <= 1'b0;
      sdaOe      <= 1'b0;
      strobeOut  <= 1'b1;
      busCondOut <= 1'b0;
    end else begin
      done       <= 1'b0;
      sclOe      <= sclLowNext;
      sdaOe      <= sdaLowNext;
      strobeOut  <= !strobeLow;
      busCondOut <= busCondNext;
      if (idle) begin
        if (start) begin
          state     <= ST_START;
          q         <= '0;
          devReg    <= devSel;
          abortFlag <= 1'b0;
          error     <= 1'b0;
        end
      end else if (tick) begin
        q <= q + 1'b1;
        if (state == ST_WACK && byteCnt == 2'd1 && q == 2'd0) strobeLow <= 1'b1;
        if (state == ST_WACK && byteCnt == 2'd2 && q == 2'd1) strobeLow <= 1'b0;
        if (q == 2'd3) begin
          unique case (state)
            ST_START: begin
              state   <= ST_WBIT;
              bitCnt  <= '0;
              byteCnt <= '0;
            end
            ST_WBIT: begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == 3'd7) state <= ST_WACK;
            end
            ST_WACK: begin
              if (sampledBit) begin
                state     <= ST_STOP;
                abortFlag <= 1'b1;
                strobeLow <= 1'b0;
              end else if (byteCnt == 2'd0) begin
                state   <= ST_WBIT;
                bitCnt  <= '0;
                byteCnt <= 2'd1;
              end else if (byteCnt == 2'd1) begin
                state <= ST_RESTART;
              end else begin
                state  <= ST_RBIT;
                bitCnt <= '0;
              end
            end
            ST_RESTART: begin
              state   <= ST_WBIT;
              bitCnt  <= '0;
              byteCnt <= 2'd2;
            end
            ST_RBIT: begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == 3'd7) state <= ST_MACK;
            end
            ST_MACK: state <= ST_STOP;
            ST_STOP: begin
              state     <= ST_IDLE;
              strobeLow <= 1'b0;
              done      <= 1'b1;
              error     <= abortFlag;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  a_r3_sda_steady_while_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    !sclOe && $past(!sclOe) && !busCondOut && $past(!busCondOut) |-> $stable(sdaOe));

  a_r5_strobe_falls_in_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobeOut) |-> sclOe);

  a_r5_strobe_rises_with_scl: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeOut) && !abortFlag |-> !sclOe && $past(sclOe));

  a_r6_done_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_error_only_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> done);

  a_r8_select_held_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    !idle && $past(!idle) |-> $stable(devReg));

endmodule

// File: rtl/gc_addr_reader.sv
module gc_addr_reader
  import gcr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] divider,
  input  logic [2:0]       devSel,
  input  logic             sdaIn,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             strobeOut,
  output logic [7:0]       rdData,
  output logic             done,
  output logic             error
);

  dpCtl_t ctl;
  logic   tick;
  logic   txBit;
  logic   sampledBit;

  gcr_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .devSel     (devSel),
    .tick       (tick),
    .txBit      (txBit),
    .sampledBit (sampledBit),
    .ctl        (ctl),
    .sclOe      (sclOe),
    .sdaOe      (sdaOe),
    .strobeOut  (strobeOut),
    .done       (done),
    .error      (error)
  );

  gcr_datapath #(.DIV_W(DIV_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .divider    (divider),
    .sdaIn      (sdaIn),
    .tick       (tick),
    .txBit      (txBit),
    .sampledBit (sampledBit),
    .rdData     (rdData)
  );

endmodule

// File: tb/gc_addr_reader_bench.sv
module gc_addr_reader_bench;

  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [DIV_W-1:0] divider = '0;
  logic [2:0]       devSel = '0;
  logic             tgtPull = 1'b0;
  logic             sdaIn;
  logic             sclOe, sdaOe, strobeOut, done, error;
  logic [7:0]       rdData;

  int checks = 0;
  int errors = 0;

  assign sdaIn = !(sdaOe || tgtPull);

  always #10 clk = !clk;

  gc_addr_reader #(.DIV_W(DIV_W)) u_gc_addr_reader (
    .clk(clk), .rstN(rstN), .start(start), .divider(divider), .devSel(devSel),
    .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe), .strobeOut(strobeOut),
    .rdData(rdData), .done(done), .error(error)
  );

  typedef struct packed {
    logic scl;
    logic sda;
    logic stb;
    logic pull;
  } qv_t;

  qv_t   plan[$];
  string sdaTag[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // patterns indexed [3-phase]: bit 3 is phase 0
  function automatic void addSlot(input logic [3:0] sclP, input logic [3:0] sdaP,
                                  input logic [3:0] stbP, input logic pull, input string tag);
    for (int p = 0; p < 4; p++) begin
      plan.push_back('{sclP[3-p], sdaP[3-p], stbP[3-p], pull});
      sdaTag.push_back(tag);
    end
  endfunction

  function automatic void buildPlan(input logic [2:0] dev, input logic [7:0] rd, input int nackAt);
    logic [7:0] b;
    plan.delete();
    sdaTag.delete();
    addSlot(4'b0000, 4'b0011, 4'b1111, 1'b0, "R3");
    for (int k = 0; k < 3; k++) begin
      b = (k == 0) ? 8'h00 : (k == 1) ? 8'h0C : {4'b1100, dev, 1'b1};
      if (k == 2) addSlot(4'b1000, 4'b0011, 4'b0000, 1'b0, "R3");
      for (int i = 7; i >= 0; i--)
        addSlot(4'b1100, {4{!b[i]}}, (k == 2) ? 4'b0000 : 4'b1111, 1'b0, "R3");
      addSlot(4'b1100, 4'b0000, (k == 0) ? 4'b1111 : (k == 1) ? 4'b1000 : 4'b0011,
              (nackAt != k), "R4");
      if (nackAt == k) begin
        addSlot(4'b1000, 4'b1100, 4'b1111, 1'b0, "R7");
        return;
      end
    end
    for (int i = 7; i >= 0; i--)
      addSlot(4'b1100, 4'b0000, 4'b1111, !rd[i], "R6");
    addSlot(4'b1100, 4'b1111, 4'b1111, 1'b0, "R6");
    addSlot(4'b1000, 4'b1100, 4'b1111, 1'b0, "R6");
  endfunction

  task automatic runTxn(input int d, input logic [2:0] dev, input logic [7:0] rd,
                        input int nackAt, input bit poke);
    int   total;
    int   doneAt;
    logic [7:0] prevRd;
    qv_t  e;
    string tg;
    buildPlan(dev, rd, nackAt);
    total  = plan.size() * (d + 1);
    doneAt = -1;
    prevRd = rdData;
    @(negedge clk);
    divider = d[DIV_W-1:0];
    devSel  = dev;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < total + 4; c++) begin
      @(negedge clk);
      if (c / (d + 1) < plan.size()) begin
        e  = plan[c / (d + 1)];
        tg = sdaTag[c / (d + 1)];
      end else begin
        e  = '{1'b0, 1'b0, 1'b1, 1'b0};
        tg = "R6";
      end
      tgtPull = e.pull;
      if (poke && c == 40) begin
        start   = 1'b1;
        divider = DIV_W'(d + 5);
        devSel  = ~dev;
      end
      if (poke && c == 41) start = 1'b0;
      check(sclOe == e.scl, "R2 scl", sclOe, e.scl);
      check(sdaOe == e.sda, tg, sdaOe, e.sda);
      check(strobeOut == e.stb, "R5 strobe", strobeOut, e.stb);
      check(done == (c == total - 1), (nackAt >= 0) ? "R7 done" : "R6 done", done, (c == total - 1));
      if (done) doneAt = c;
    end
    tgtPull = 1'b0;
    if (poke) check(doneAt == total - 1, "R8 length", doneAt, total - 1);
    if (nackAt >= 0) begin
      check(error == 1'b1, "R7 error", error, 1);
      check(rdData == prevRd, "R7 rdData kept", rdData, prevRd);
    end else begin
      check(error == 1'b0, "R6 error", error, 0);
      check(rdData == rd, "R6 rdData", rdData, rd);
    end
  endtask

  initial begin
    #4_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sclOe == 1'b0,     "R1 sclOe",  sclOe, 0);
    check(sdaOe == 1'b0,     "R1 sdaOe",  sdaOe, 0);
    check(strobeOut == 1'b1, "R1 strobe", strobeOut, 1);
    check(done == 1'b0,      "R1 done",   done, 0);
    check(error == 1'b0,     "R1 error",  error, 0);
    runTxn(3, 3'b101, 8'hB4, -1, 1'b0);   // R2 R3 R4 R5 R6 main pattern
    runTxn(0, 3'b010, 8'h4A, -1, 1'b0);   // R2 fastest divider
    runTxn(1, 3'b111, 8'h5C, 0, 1'b0);    // R7 nack on byte 1
    runTxn(2, 3'b001, 8'hFF, 1, 1'b0);    // R7 nack on byte 2, strobe already low
    runTxn(1, 3'b110, 8'h00, 2, 1'b0);    // R7 nack on byte 3
    runTxn(2, 3'b011, 8'hE2, -1, 1'b1);   // R8 start pulse while busy
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule